// File: doc/BRIEF.md
# Write Status Polling Responder

This block stands in the read-data path of a nonvolatile memory bank while that bank runs a self-timed program or erase. A one-cycle launch pulse carries the operation kind and the most significant bit of the byte being programmed. From that point an internal cycle counter measures the operation time, and any read of the bank gets a status byte instead of array contents. The top bit of the status byte tells the host whether the operation has finished. The next bit flips on every fresh read strobe, so two back-to-back reads that differ show that work is still in progress.

When the timed operation ends, the top bit shows its final, true value at once. The lower bits may still be unsettled at that point, so they stay at a fixed fill pattern for a further, separately counted settling window. After that the block passes array data from its storage input straight to the output again. The block does not decode commands and does not hold the array. It only shapes what a read returns. Operation lengths and the settling length are parameters given in clock cycles.

Top module: `busy_poll_responder`

## Requirements
- R1: While reset is applied, and after it, with no launch, `busy_o` and `settle_o` are 0 and `dout_o` equals `array_i`.
- R2: A `start_i` pulse sampled while the block is idle holds `busy_o` high for exactly PROG_CYCLES clock cycles when `op_erase_i` is 0, and for exactly ERASE_CYCLES cycles when `op_erase_i` is 1. The first busy cycle is the one after the sampling edge.
- R3: During a program (busy, op 0), bit DATA_W-1 of `dout_o` reads as the inverse of the latched `prog_msb_i`.
- R4: During an erase (busy, op 1), bit DATA_W-1 of `dout_o` reads as 0.
- R5: Bit DATA_W-2 of `dout_o` is 0 on the first busy cycle. It inverts once after each clock edge at which `rd_i` is sampled high while it was low at the previous edge and the block is busy. A strobe that is held high for several cycles counts as one read.
- R6: During busy and during settling, bits DATA_W-3..0 of `dout_o` equal the FILL parameter.
- R7: After busy ends, `settle_o` is high for exactly SETTLE_CYCLES cycles (never together with `busy_o`). During that window bit DATA_W-1 shows the true value (the latched `prog_msb_i` for a program, 1 for an erase), and bit DATA_W-2 holds its last busy value whatever `rd_i` does.
- R8: When neither busy nor settling, `dout_o` equals `array_i` in every bit, in the same cycle.
- R9: A `start_i` pulse that arrives while busy or settling is ignored. The running operation keeps its kind, its data bit and its remaining length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Launch pulse for a timed operation |
| op_erase_i | input | 1 | Operation kind at launch: 0 program, 1 erase |
| prog_msb_i | input | 1 | Most significant bit of the byte being programmed |
| rd_i | input | 1 | Read strobe, active high; a rising edge is one read |
| array_i | input | DATA_W | Array contents for the current read address |
| dout_o | output | DATA_W | Read data returned to the host |
| busy_o | output | 1 | Timed operation running |
| settle_o | output | 1 | Post-completion settling window |

## Verification
The bench builds the block with PROG_CYCLES=6, ERASE_CYCLES=11, SETTLE_CYCLES=4 and FILL=6'h2A. With these values a full program or erase, including the settling window, fits in about twenty cycles. This makes it possible to sweep every combination of operation kind, data bit, read-strobe pattern (short pulses, stretched pulses, no reads) and late launch attempts during busy and during settling. The short counters also put the exact cycle count of each phase within reach of a direct comparison. All 256 array values are also checked for straight passthrough while the block is idle.

// File: rtl/bpr_pkg.sv
package bpr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_BUSY   = 2'd1,
    PH_SETTLE = 2'd2
  } phase_e;

  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } op_e;

endpackage

// File: rtl/bpr_timer.sv
module bpr_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign zero_o = (cnt_q == '0);

  always_comb begin
    cnt_en = load_i | (run_i & ~zero_o);
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (run_i && !zero_o) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/bpr_toggle.sv
module bpr_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_i,
  input  logic clear_i,
  input  logic en_i,
  output logic tog_o
);

  logic rd_q;
  logic tog_q;
  logic tog_d;
  logic rd_edge;
  logic tog_en;

  assign rd_edge = rd_i & ~rd_q;
  assign tog_o   = tog_q;

  always_comb begin
    tog_en = clear_i | (en_i & rd_edge);
    tog_d  = clear_i ? 1'b0 : ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
    end else begin
      rd_q <= rd_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
    end else if (tog_en) begin
      tog_q <= tog_d;
    end
  end

endmodule

// File: rtl/bpr_outmux.sv
module bpr_outmux
  import bpr_pkg::*;
#(
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-3:0] FILL   = '0
) (
  input  phase_e            phase_i,
  input  logic              erase_i,
  input  logic              msb_i,
  input  logic              tog_i,
  input  logic [DATA_W-1:0] array_i,
  output logic [DATA_W-1:0] dout_o
);

  logic poll_busy;
  logic poll_done;

  assign poll_busy = erase_i ? 1'b0 : ~msb_i;
  assign poll_done = erase_i ? 1'b1 : msb_i;

  always_comb begin
    unique case (phase_i)
      PH_BUSY:   dout_o = {poll_busy, tog_i, FILL};
      PH_SETTLE: dout_o = {poll_done, tog_i, FILL};
      default:   dout_o = array_i;
    endcase
  end

endmodule

// File: rtl/busy_poll_responder.sv
module busy_poll_responder
  import bpr_pkg::*;
#(
  parameter int                DATA_W        = 8,
  parameter int                PROG_CYCLES   = 5000,
  parameter int                ERASE_CYCLES  = 6250000,
  parameter int                SETTLE_CYCLES = 250,
  parameter logic [DATA_W-3:0] FILL          = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              op_erase_i,
  input  logic              prog_msb_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] array_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              busy_o,
  output logic              settle_o
);

  localparam int LONG_OP    = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int LONGEST    = (SETTLE_CYCLES > LONG_OP) ? SETTLE_CYCLES : LONG_OP;
  localparam int CNT_W      = (LONGEST < 2) ? 1 : $clog2(LONGEST);
  localparam bit HAS_SETTLE = (SETTLE_CYCLES > 0);
  localparam logic [CNT_W-1:0] PROG_LD   = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LD  = CNT_W'(ERASE_CYCLES - 1);
  localparam logic [CNT_W-1:0] SETTLE_LD = HAS_SETTLE ? CNT_W'(SETTLE_CYCLES - 1) : '0;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  phase_e           phase_q;
  phase_e           phase_d;
  op_e              op_q;
  logic             msb_q;
  logic             erase_q;
  logic             launch;
  logic             tmr_zero;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tog;

  assign launch  = (phase_q == PH_IDLE) & start_i;
  assign erase_q = (op_q == OP_ERASE);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (start_i)  phase_d = PH_BUSY;
      PH_BUSY:   if (tmr_zero) phase_d = HAS_SETTLE ? PH_SETTLE : PH_IDLE;
      PH_SETTLE: if (tmr_zero) phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  // operation descriptor, captured only at launch
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      op_q  <= OP_PROG;
      msb_q <= 1'b0;
    end else if (launch) begin
      op_q  <= op_erase_i ? OP_ERASE : OP_PROG;
      msb_q <= prog_msb_i;
    end
  end

  always_comb begin
    tmr_load = launch | ((phase_q == PH_BUSY) & tmr_zero & HAS_SETTLE);
    if (launch) begin
      tmr_val = op_erase_i ? ERASE_LD : PROG_LD;
    end else begin
      tmr_val = SETTLE_LD;
    end
  end

  bpr_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .run_i      (phase_q != PH_IDLE),
    .zero_o     (tmr_zero)
  );

  bpr_toggle u_toggle (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .rd_i    (rd_i),
    .clear_i (launch),
    .en_i    (phase_q == PH_BUSY),
    .tog_o   (tog)
  );

  bpr_outmux #(
    .DATA_W (DATA_W),
    .FILL   (FILL)
  ) u_outmux (
    .phase_i (phase_q),
    .erase_i (erase_q),
    .msb_i   (msb_q),
    .tog_i   (tog),
    .array_i (array_i),
    .dout_o  (dout_o)
  );

  assign busy_o   = (phase_q == PH_BUSY);
  assign settle_o = (phase_q == PH_SETTLE);

endmodule

// File: rtl/bpr_chk.sv
module bpr_chk #(
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-3:0] FILL   = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              settle_o,
  input logic [DATA_W-1:0] dout_o,
  input logic [DATA_W-1:0] array_i,
  input logic              erase_q,
  input logic              msb_q
);

  assert_launch_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  assert_prog_poll_inverse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !erase_q) |-> (dout_o[DATA_W-1] != msb_q));

  assert_erase_poll_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && erase_q) |-> !dout_o[DATA_W-1]);

  assert_fill_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o || settle_o) |-> (dout_o[DATA_W-3:0] == FILL));

  assert_phase_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && settle_o));

  assert_settle_toggle_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_o && $past(settle_o)) |-> $stable(dout_o[DATA_W-2]));

  assert_idle_passthrough_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !settle_o) |-> (dout_o == array_i));

  assert_op_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((busy_o || settle_o) && $past(busy_o || settle_o)) |-> ($stable(erase_q) && $stable(msb_q)));

endmodule

bind busy_poll_responder bpr_chk #(
  .DATA_W (DATA_W),
  .FILL   (FILL)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .settle_o (settle_o),
  .dout_o   (dout_o),
  .array_i  (array_i),
  .erase_q  (erase_q),
  .msb_q    (msb_q)
);

// File: tb/busy_poll_responder_tb.sv
`timescale 1ns/1ps
module busy_poll_responder_tb;

  localparam int         DW   = 8;
  localparam int         PRG  = 6;
  localparam int         ERS  = 11;
  localparam int         SET  = 4;
  localparam logic [5:0] FILL = 6'h2A;
  localparam int         WD   = 150000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start, op_erase, prog_msb, rd;
  logic [DW-1:0] array_v;
  logic [DW-1:0] dout;
  logic          busy, settle;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  busy_poll_responder #(
    .DATA_W        (DW),
    .PROG_CYCLES   (PRG),
    .ERASE_CYCLES  (ERS),
    .SETTLE_CYCLES (SET),
    .FILL          (FILL)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .op_erase_i (op_erase),
    .prog_msb_i (prog_msb),
    .rd_i       (rd),
    .array_i    (array_v),
    .dout_o     (dout),
    .busy_o     (busy),
    .settle_o   (settle)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // rmode 0: one-cycle strobes; 1: two-cycle strobes; 2: no reads
  task automatic run_op(input logic er, input logic msb, input int rmode, input logic poke);
    int   n, bc, sc;
    logic tog_exp, rd_prev, b7;
    n = er ? ERS : PRG;
    bc = 0; sc = 0; tog_exp = 1'b0; rd_prev = 1'b0;
    rd = 1'b0; op_erase = er; prog_msb = msb; start = 1'b1;
    step();
    start = 1'b0;
    for (int i = 0; i < n + SET + 3; i++) begin
      rd       = (rmode == 0) ? (i % 2 == 0) : (rmode == 1) ? (i % 3 != 2) : 1'b0;
      start    = poke && (i == 2 || i == n + 1);
      op_erase = start ? ~er : er;
      prog_msb = start ? ~msb : msb;
      array_v  = DW'(i * 37 + (msb ? 5 : 0));
      @(negedge clk);
      if (busy) begin
        bc++;
        b7 = er ? 1'b0 : ~msb;
        if (er) chk(dout[7] == b7, "R4 erase poll bit", int'(dout[7]), int'(b7));
        else    chk(dout[7] == b7, "R3 program poll bit", int'(dout[7]), int'(b7));
        chk(dout[6] == tog_exp, "R5 toggle bit", int'(dout[6]), int'(tog_exp));
        chk(dout[5:0] == FILL, "R6 fill bits busy", int'(dout[5:0]), int'(FILL));
        if (rd && !rd_prev) tog_exp = ~tog_exp;
      end else if (settle) begin
        sc++;
        b7 = er ? 1'b1 : msb;
        chk(dout[7] == b7, "R7 true bit in settle", int'(dout[7]), int'(b7));
        chk(dout[6] == tog_exp, "R7 toggle frozen", int'(dout[6]), int'(tog_exp));
        chk(dout[5:0] == FILL, "R6 fill bits settle", int'(dout[5:0]), int'(FILL));
      end else begin
        chk(dout == array_v, "R8 idle passthrough", int'(dout), int'(array_v));
      end
      rd_prev = rd;
      step();
    end
    rd = 1'b0; start = 1'b0;
    chk(bc == n, "R2 R9 busy length", bc, n);
    chk(sc == SET, "R7 R9 settle length", sc, SET);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WD, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op_erase = 1'b0; prog_msb = 1'b0; rd = 1'b0;
    array_v = 8'h5C;
    repeat (3) step();
    @(negedge clk);
    chk(!busy, "R1 busy in reset", int'(busy), 0);
    chk(!settle, "R1 settle in reset", int'(settle), 0);
    chk(dout == array_v, "R1 data in reset", int'(dout), int'(array_v));
    step();
    rst_n = 1'b1;
    for (int v = 0; v < 256; v++) begin
      array_v = DW'(v);
      @(negedge clk);
      chk(dout == array_v && !busy && !settle, "R8 R1 idle sweep", int'(dout), v);
      step();
    end
    for (int er = 0; er < 2; er++)
      for (int m = 0; m < 2; m++)
        for (int rm = 0; rm < 3; rm++)
          for (int p = 0; p < 2; p++) begin
            run_op(er[0], m[0], rm, p[0]);
            step();
          end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule